// File: doc/BRIEF.md
# Mailbox Command Sequencer

This engine runs one complete request/reply exchange with a coprocessor that shares a small message RAM and two mailbox registers with the host. A one-cycle `start` pulse carries a command index. The engine builds a fixed five-word message from a constant table and writes it over a 32-bit register-bus master port. It then rings the coprocessor and polls the reply mailbox at a programmable spacing, up to a bounded number of polls. When a reply arrives it reads back the five message words. It clears the reply mailbox on both the reply path and the timeout path, and then reports.

The report is a one-cycle `done` pulse together with the five reply words, a 32-bit status code and a decoded tagged pointer taken from the reply argument. The status code is 1 for success. Any error code has bit 31 set plus one cause bit. The report outputs hold their values until the next accepted `start`.

The state machine has eight states:
- IDLE waits for `start`. It goes to SEND for a valid index and straight to FINISH for an index of 3.
- SEND writes the five message words and goes to RING after the fifth acknowledged write.
- RING writes 1 to the coprocessor mailbox and then goes to POLL.
- POLL reads the reply mailbox. A nonzero value goes to FETCH. A zero value on the last allowed poll goes to RELEASE. Any other zero value goes to GAP.
- GAP waits `POLL_GAP` cycles and then returns to POLL.
- FETCH reads the five message words and then goes to RELEASE.
- RELEASE writes 0 to the reply mailbox and then goes to FINISH.
- FINISH raises `done` for one cycle and then returns to IDLE.

Top module: `mbox_cmd_seq`

## Requirements
- R1: While reset is active and after it, with no `start`, `done`, `busy` and `bus_req` are 0 and `status` is 0.
- R2: For command index k (0, 1 or 2), the engine writes five words to byte addresses 0x100, 0x104, 0x108, 0x10C and 0x110, in that order. The words are: header = 1; command = 1 for k=0 and 2 otherwise; argument count = 1; argument = 2 for k=2 and 1 otherwise; checksum = modulo-2^32 sum of the first four words. This gives {1,1,1,1,4}, {1,2,1,1,5} and {1,2,1,2,6}.
- R3: After the fifth message write, exactly one write of value 1 goes to address 0x010.
- R4: The reply mailbox at 0x014 is read up to `POLL_MAX` times. Consecutive polls are spaced by `POLL_GAP` idle cycles plus the bus latency. A nonzero value on the final allowed poll still counts as a reply.
- R5: On a reply, the five words at 0x100 to 0x110 are read in order and presented on `reply_w0` to `reply_w4`. If the checksum holds, `status` equals the nonzero mailbox value.
- R6: If no poll returns nonzero, `status` is 0x80000010 and all five reply words are 0.
- R7: Before `done`, one write of value 0 goes to 0x014, on both the reply path and the timeout path.
- R8: If `reply_w0+reply_w1+reply_w2+reply_w3` (mod 2^32) differs from `reply_w4`, `status` is 0x80000004, whatever the mailbox value was.
- R9: `ptr_type` is `reply_w3[31:28]` and `ptr_offset` is `reply_w3[27:0]`. Type 1 means message RAM and type 0 means data RAM. `ptr_fatal` is 1 exactly when the type is above 1.
- R10: A `start` with index 3 gives `done` on the next cycle with `status` 0x80000002, and no bus transaction is made.
- R11: Once `bus_req` is raised, it and `bus_we`, `bus_addr` and `bus_wdata` hold steady until a cycle with `bus_ack` high completes the transfer.
- R12: `done` is a single-cycle pulse. A `start` that arrives while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, sampled in IDLE |
| cmd_idx | input | 2 | Command index; 3 is invalid |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 12 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer completes in a cycle with req and ack high |
| bus_rdata | input | 32 | Read data, valid with ack |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 32 | Result code |
| reply_w0 | output | 32 | Reply header word |
| reply_w1 | output | 32 | Reply command word |
| reply_w2 | output | 32 | Reply argument count |
| reply_w3 | output | 32 | Reply argument (tagged pointer) |
| reply_w4 | output | 32 | Reply checksum word |
| ptr_type | output | 4 | Pointer type field |
| ptr_offset | output | 28 | Pointer offset field |
| ptr_fatal | output | 1 | Pointer type is neither 0 nor 1 |

## Verification
A wrong word index or state shows on the bus within one transfer: a wrong address or data word appears in the very next message write or read, and the bench log of the slave catches it. A poll-budget or gap counter that is off by one changes the poll count or spacing on the timeout run. It can also turn the final-poll reply into a timeout, which is visible at `status` when `done` rises. A wrong selection in status priority, checksum or pointer decode shows as a wrong code or field value in the same cycle `done` pulses.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int MSG_WORDS = 5;
    localparam int CMD_W     = 2;
    localparam int CMD_COUNT = 3;
    localparam int PTYPE_W   = 4;
    localparam int POFFS_W   = WORD_W - PTYPE_W;

    localparam logic [ADDR_W-1:0] ADDR_MSG_BASE = 12'h100;
    localparam logic [ADDR_W-1:0] ADDR_RING     = 12'h010;
    localparam logic [ADDR_W-1:0] ADDR_REPLY    = 12'h014;

    localparam logic [WORD_W-1:0] STS_OK      = 32'h0000_0001;
    localparam logic [WORD_W-1:0] STS_INVAL   = 32'h8000_0002;
    localparam logic [WORD_W-1:0] STS_CHKSUM  = 32'h8000_0004;
    localparam logic [WORD_W-1:0] STS_TIMEOUT = 32'h8000_0010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_RING,
        ST_POLL,
        ST_GAP,
        ST_FETCH,
        ST_RELEASE,
        ST_FINISH
    } seq_state_e;
endpackage

// File: rtl/mbox_cmd_table.sv
module mbox_cmd_table
    import mbox_pkg::*;
(
    input  logic [CMD_W-1:0]  cmd,
    input  logic [2:0]        sel,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] base [MSG_WORDS-1];
    logic [WORD_W-1:0] sum;

    always_comb begin
        base[0] = 32'd1;
        base[1] = (cmd == 2'd0) ? 32'd1 : 32'd2;
        base[2] = 32'd1;
        base[3] = (cmd == 2'd2) ? 32'd2 : 32'd1;
        sum = '0;
        for (int i = 0; i < MSG_WORDS - 1; i++) begin
            sum = sum + base[i];
        end
        word = (sel == 3'(MSG_WORDS - 1)) ? sum : base[sel[1:0]];
    end
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int POLL_GAP = 625,
    parameter int POLL_MAX = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic poll_taken,
    input  logic gap_load,
    input  logic in_gap,
    output logic last_poll,
    output logic gap_done
);
    localparam int BUDGET_W = $clog2(POLL_MAX + 1);
    localparam int GAP_W    = $clog2(POLL_GAP + 1);

    logic [BUDGET_W-1:0] polls_q;
    logic [GAP_W-1:0]    gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            polls_q <= '0;
            gap_q   <= '0;
        end else begin
            if (arm) begin
                polls_q <= '0;
            end else if (poll_taken) begin
                polls_q <= polls_q + 1'b1;
            end
            if (gap_load) begin
                gap_q <= GAP_W'(POLL_GAP - 1);
            end else if (in_gap && gap_q != '0) begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign last_poll = (polls_q == BUDGET_W'(POLL_MAX - 1));
    assign gap_done  = in_gap && (gap_q == '0);
endmodule

// File: rtl/mbox_reply_eval.sv
module mbox_reply_eval
    import mbox_pkg::*;
(
    input  logic [MSG_WORDS-1:0][WORD_W-1:0] words,
    input  logic [WORD_W-1:0]                resp,
    input  logic                             timed_out,
    input  logic                             bad_idx,
    output logic [WORD_W-1:0]                status,
    output logic [PTYPE_W-1:0]               ptr_type,
    output logic [POFFS_W-1:0]               ptr_offset,
    output logic                             ptr_fatal
);
    logic [WORD_W-1:0] sum;

    always_comb begin
        sum = '0;
        for (int i = 0; i < MSG_WORDS - 1; i++) begin
            sum = sum + words[i];
        end
        if (bad_idx) begin
            status = STS_INVAL;
        end else if (timed_out) begin
            status = STS_TIMEOUT;
        end else if (sum != words[MSG_WORDS-1]) begin
            status = STS_CHKSUM;
        end else begin
            status = resp;
        end
    end

    assign ptr_type   = words[3][WORD_W-1 -: PTYPE_W];
    assign ptr_offset = words[3][POFFS_W-1:0];
    assign ptr_fatal  = (ptr_type > PTYPE_W'(1));
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
    import mbox_pkg::*;
#(
    parameter int POLL_GAP = 625,
    parameter int POLL_MAX = 200000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          cmd_idx,
    output logic                bus_req,
    output logic                bus_we,
    output logic [11:0]         bus_addr,
    output logic [31:0]         bus_wdata,
    input  logic                bus_ack,
    input  logic [31:0]         bus_rdata,
    output logic                busy,
    output logic                done,
    output logic [31:0]         status,
    output logic [31:0]         reply_w0,
    output logic [31:0]         reply_w1,
    output logic [31:0]         reply_w2,
    output logic [31:0]         reply_w3,
    output logic [31:0]         reply_w4,
    output logic [3:0]          ptr_type,
    output logic [27:0]         ptr_offset,
    output logic                ptr_fatal
);
    localparam logic [CMD_W-1:0] CMD_LAST  = CMD_W'(CMD_COUNT - 1);
    localparam logic [2:0]       WORD_LAST = 3'(MSG_WORDS - 1);

    seq_state_e state, nxt;

    logic [2:0]                       word_idx;
    logic [CMD_W-1:0]                 cmd_q;
    logic [MSG_WORDS-1:0][WORD_W-1:0] rx_q;
    logic [WORD_W-1:0]                resp_q;
    logic                             tmo_q;
    logic                             bad_idx_q;
    logic [WORD_W-1:0]                tbl_word;
    logic                             acc, launch, reject, last_word;
    logic                             reply_seen, last_poll, gap_done;
    logic                             poll_taken, gap_load;

    assign acc        = bus_req && bus_ack;
    assign launch     = (state == ST_IDLE) && start;
    assign reject     = cmd_idx > CMD_LAST;
    assign last_word  = (word_idx == WORD_LAST);
    assign reply_seen = (bus_rdata != '0);
    assign poll_taken = acc && (state == ST_POLL);
    assign gap_load   = poll_taken && !reply_seen && !last_poll;

    mbox_cmd_table u_table (
        .cmd  (cmd_q),
        .sel  (word_idx),
        .word (tbl_word)
    );

    mbox_poll_timer #(
        .POLL_GAP (POLL_GAP),
        .POLL_MAX (POLL_MAX)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (launch),
        .poll_taken (poll_taken),
        .gap_load   (gap_load),
        .in_gap     (state == ST_GAP),
        .last_poll  (last_poll),
        .gap_done   (gap_done)
    );

    mbox_reply_eval u_eval (
        .words      (rx_q),
        .resp       (resp_q),
        .timed_out  (tmo_q),
        .bad_idx    (bad_idx_q),
        .status     (status),
        .ptr_type   (ptr_type),
        .ptr_offset (ptr_offset),
        .ptr_fatal  (ptr_fatal)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = reject ? ST_FINISH : ST_SEND;
            ST_SEND:    if (acc && last_word) nxt = ST_RING;
            ST_RING:    if (acc) nxt = ST_POLL;
            ST_POLL: begin
                if (acc) begin
                    if (reply_seen)     nxt = ST_FETCH;
                    else if (last_poll) nxt = ST_RELEASE;
                    else                nxt = ST_GAP;
                end
            end
            ST_GAP:     if (gap_done) nxt = ST_POLL;
            ST_FETCH:   if (acc && last_word) nxt = ST_RELEASE;
            ST_RELEASE: if (acc) nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_SEND: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_MSG_BASE + ADDR_W'({word_idx, 2'b00});
                bus_wdata = tbl_word;
            end
            ST_RING: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_RING;
                bus_wdata = 32'd1;
            end
            ST_POLL: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_REPLY;
            end
            ST_GAP: ;
            ST_FETCH: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_MSG_BASE + ADDR_W'({word_idx, 2'b00});
            end
            ST_RELEASE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = ADDR_REPLY;
            end
            ST_FINISH: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx  <= '0;
            cmd_q     <= '0;
            rx_q      <= '0;
            resp_q    <= '0;
            tmo_q     <= 1'b0;
            bad_idx_q <= 1'b0;
        end else begin
            if (launch) begin
                word_idx  <= '0;
                cmd_q     <= cmd_idx;
                rx_q      <= '0;
                resp_q    <= '0;
                tmo_q     <= 1'b0;
                bad_idx_q <= reject;
            end
            if (acc && (state == ST_SEND || state == ST_FETCH)) begin
                word_idx <= last_word ? 3'd0 : word_idx + 3'd1;
            end
            if (acc && state == ST_FETCH) begin
                rx_q[word_idx] <= bus_rdata;
            end
            if (poll_taken) begin
                if (reply_seen)     resp_q <= bus_rdata;
                else if (last_poll) tmo_q  <= 1'b1;
            end
        end
    end

    assign reply_w0 = rx_q[0];
    assign reply_w1 = rx_q[1];
    assign reply_w2 = rx_q[2];
    assign reply_w3 = rx_q[3];
    assign reply_w4 = rx_q[4];
endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [1:0]  cmd_idx,
    input logic        bus_req,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack,
    input logic        busy,
    input logic        done,
    input logic [31:0] status
);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req);

    a_r11_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    a_r10_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !done && cmd_idx == 2'd3 |=> done && status == 32'h8000_0002);

    a_r5_status_form: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status != 32'd0);
endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_idx   (cmd_idx),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .busy      (busy),
    .done      (done),
    .status    (status)
);

// File: tb/mbox_cmd_seq_bench.sv
module mbox_cmd_seq_bench;
    localparam int GAP  = 3;
    localparam int PMAX = 4;
    localparam logic [7:0] NEVER = 8'hFF;

    typedef struct packed {
        logic [1:0]  idx;
        logic [7:0]  delay;
        logic [31:0] resp;
        logic [31:0] arg;
        logic        bad;
        logic [31:0] exp_sts;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 8'd0, 32'h0000_0001, 32'h1000_0020, 1'b0, 32'h0000_0001},
        '{2'd1, 8'd3, 32'h0000_0001, 32'h0000_0040, 1'b0, 32'h0000_0001},
        '{2'd2, 8'd1, 32'h0000_0001, 32'h2000_0100, 1'b0, 32'h0000_0001},
        '{2'd1, 8'd0, 32'h8000_0002, 32'h1000_0000, 1'b0, 32'h8000_0002},
        '{2'd0, 8'd2, 32'h0000_0001, 32'h1000_0008, 1'b1, 32'h8000_0004},
        '{2'd2, 8'd0, 32'h8000_0008, 32'h0000_0000, 1'b1, 32'h8000_0004}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] cmd_idx = 2'd0;
    logic bus_req, bus_we, bus_ack;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic busy, done, ptr_fatal;
    logic [31:0] status, reply_w0, reply_w1, reply_w2, reply_w3, reply_w4;
    logic [3:0] ptr_type;
    logic [27:0] ptr_offset;

    always #4 clk = ~clk;

    mbox_cmd_seq #(.POLL_GAP(GAP), .POLL_MAX(PMAX)) u_mbox_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .status(status),
        .reply_w0(reply_w0), .reply_w1(reply_w1), .reply_w2(reply_w2),
        .reply_w3(reply_w3), .reply_w4(reply_w4),
        .ptr_type(ptr_type), .ptr_offset(ptr_offset), .ptr_fatal(ptr_fatal)
    );

    // Bus slave and coprocessor model
    logic        clr_log = 1'b0;
    logic [7:0]  cfg_delay = 8'd0;
    logic [31:0] cfg_resp = 32'd0;
    logic [31:0] cfg_reply [5];
    logic [31:0] msg_ram [5];
    logic [31:0] sent [5];
    int n_txn, n_ring, n_hostwr, n_polls, cyc, first_st, last_st, sent_order;
    logic [31:0] ring_val;
    logic host_zero;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || clr_log) begin
            bus_ack <= 1'b0;
            bus_rdata <= '0;
            n_txn <= 0; n_ring <= 0; n_hostwr <= 0; n_polls <= 0;
            ring_val <= '0; host_zero <= 1'b0; sent_order <= 0;
            first_st <= 0; last_st <= 0;
            for (int i = 0; i < 5; i++) sent[i] <= '0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            n_txn <= n_txn + 1;
            if (bus_we) begin
                if (bus_addr >= 12'h100 && bus_addr <= 12'h110) begin
                    sent[(bus_addr - 12'h100) >> 2] <= bus_wdata;
                    msg_ram[(bus_addr - 12'h100) >> 2] <= bus_wdata;
                    if (((bus_addr - 12'h100) >> 2) != 12'(sent_order)) sent_order <= 99;
                    else sent_order <= sent_order + 1;
                end else if (bus_addr == 12'h010) begin
                    ring_val <= bus_wdata;
                    n_ring <= n_ring + 1;
                    msg_ram <= cfg_reply;
                end else if (bus_addr == 12'h014) begin
                    n_hostwr <= n_hostwr + 1;
                    host_zero <= (bus_wdata == 32'd0);
                end
            end else begin
                if (bus_addr == 12'h014) begin
                    bus_rdata <= (cfg_delay != NEVER && n_polls >= int'(cfg_delay)) ? cfg_resp : 32'd0;
                    n_polls <= n_polls + 1;
                    if (n_polls == 0) first_st <= cyc;
                    last_st <= cyc;
                end else if (bus_addr >= 12'h100 && bus_addr <= 12'h110) begin
                    bus_rdata <= msg_ram[(bus_addr - 12'h100) >> 2];
                end else begin
                    bus_rdata <= 32'hDEAD_BEEF;
                end
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear();
        @(negedge clk) clr_log = 1'b1;
        @(negedge clk) clr_log = 1'b0;
    endtask

    task automatic run(input logic [1:0] idx, output int waited);
        waited = 0;
        @(negedge clk);
        start = 1'b1;
        cmd_idx = idx;
        @(negedge clk);
        start = 1'b0;
        while (!done && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] k, input int w);
        logic [31:0] a, b;
        a = (k == 2'd0) ? 32'd1 : 32'd2;
        b = (k == 2'd2) ? 32'd2 : 32'd1;
        case (w)
            0: return 32'd1;
            1: return a;
            2: return 32'd1;
            3: return b;
            default: return 32'd2 + a + b;
        endcase
    endfunction

    initial begin
        int w;
        logic [31:0] sum;
        for (int i = 0; i < 5; i++) cfg_reply[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0 && busy == 1'b0 && bus_req == 1'b0, "R1 during reset", {29'd0, done, busy, bus_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0 && bus_req == 1'b0 && status == 32'd0, "R1 after reset", status, 32'd0);

        for (int v = 0; v < 6; v++) begin
            cfg_delay = VECS[v].delay;
            cfg_resp  = VECS[v].resp;
            cfg_reply[0] = 32'd2;
            cfg_reply[1] = cmd_word(VECS[v].idx, 1);
            cfg_reply[2] = 32'd1;
            cfg_reply[3] = VECS[v].arg;
            sum = cfg_reply[0] + cfg_reply[1] + cfg_reply[2] + cfg_reply[3];
            cfg_reply[4] = sum + {31'd0, VECS[v].bad};
            clear();
            run(VECS[v].idx, w);
            check(status == VECS[v].exp_sts, VECS[v].bad ? "R8 checksum override" : "R5 status", status, VECS[v].exp_sts);
            check({reply_w0, reply_w1, reply_w2, reply_w3, reply_w4} ==
                  {cfg_reply[0], cfg_reply[1], cfg_reply[2], cfg_reply[3], cfg_reply[4]},
                  "R5 reply words", reply_w4, cfg_reply[4]);
            for (int k = 0; k < 5; k++) begin
                check(sent[k] == cmd_word(VECS[v].idx, k), "R2 message word", sent[k], cmd_word(VECS[v].idx, k));
            end
            check(sent_order == 5, "R2 write order", 32'(sent_order), 32'd5);
            check(n_ring == 1 && ring_val == 32'd1, "R3 ring", ring_val, 32'd1);
            check(n_polls == int'(VECS[v].delay) + 1, "R4 poll count", 32'(n_polls), 32'(int'(VECS[v].delay) + 1));
            check(n_hostwr == 1 && host_zero, "R7 release", 32'(n_hostwr), 32'd1);
            check(ptr_type == VECS[v].arg[31:28] && ptr_offset == VECS[v].arg[27:0],
                  "R9 pointer fields", {ptr_type, ptr_offset}, VECS[v].arg);
            check(ptr_fatal == (VECS[v].arg[31:28] > 4'd1), "R9 fatal flag", {31'd0, ptr_fatal},
                  {31'd0, VECS[v].arg[31:28] > 4'd1});
        end

        // R6/R4: timeout after PMAX polls
        cfg_delay = NEVER;
        clear();
        run(2'd0, w);
        check(status == 32'h8000_0010, "R6 timeout status", status, 32'h8000_0010);
        check({reply_w0, reply_w1, reply_w2, reply_w3, reply_w4} == '0, "R6 words zero", reply_w3, 32'd0);
        check(n_polls == PMAX, "R4 poll budget", 32'(n_polls), 32'(PMAX));
        check(last_st - first_st == (PMAX - 1) * (GAP + 2), "R4 poll spacing",
              32'(last_st - first_st), 32'((PMAX - 1) * (GAP + 2)));
        check(n_hostwr == 1 && host_zero, "R7 release on timeout", 32'(n_hostwr), 32'd1);

        // R10: invalid index
        clear();
        run(2'd3, w);
        check(w == 0 && done, "R10 immediate done", 32'(w), 32'd0);
        check(status == 32'h8000_0002, "R10 status", status, 32'h8000_0002);
        @(negedge clk);
        check(done == 1'b0, "R12 done single cycle", {31'd0, done}, 32'd0);
        check(n_txn == 0, "R10 no bus traffic", 32'(n_txn), 32'd0);

        // R12: start while busy ignored
        cfg_delay = 8'd2;
        cfg_resp = 32'd1;
        cfg_reply[0] = 32'd2; cfg_reply[1] = 32'd1; cfg_reply[2] = 32'd1;
        cfg_reply[3] = 32'h1000_0004; cfg_reply[4] = 32'h1000_0008;
        clear();
        @(negedge clk);
        start = 1'b1; cmd_idx = 2'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; cmd_idx = 2'd3;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 2000) begin
            @(negedge clk);
            w++;
        end
        check(status == 32'd1, "R12 busy start ignored", status, 32'd1);
        check(sent[1] == 32'd1 && n_ring == 1, "R12 command unchanged", sent[1], 32'd1);
        repeat (3) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R12 stays idle", {30'd0, done, busy}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule